// File: doc/BRIEF.md
# Residue Adder for Modulus 2^n−1

This block adds two n-bit residues and returns their sum reduced modulo 2^n−1, for use inside residue-domain multiply-accumulate datapaths. Bitwise generate and propagate terms feed a Sklansky parallel-prefix carry tree. The carry leaving the top bit is returned as the carry into bit 0, which folds the reduction into the prefix network. The block needs no separate compare-and-subtract stage.

A raw sum of two residues never exceeds twice the largest residue, so one end-around correction always brings it back into range. Zero has two encodings in this arithmetic: all-zeros and all-ones. The block always emits the all-zeros form. Either operand may be all-ones, and that value is treated as zero. The result is registered, and a valid flag travels alongside it with one cycle of latency.

Top module: `residue_eac_adder`

## Requirements
- R1: When `inValid` is high at a rising edge, `sumOut` after that edge equals (opA + opB) mod (2^W − 1), computed on unsigned integers, for every operand pair in 0 .. 2^W − 1.
- R2: `sumOut` is never all-ones. Zero is always presented as all-zeros.
- R3: `outValid` is high after a rising edge exactly when `inValid` was high at that edge. The matching result appears on `sumOut` in the same cycle.
- R4: When `inValid` is low at a rising edge, `outValid` is low after it and `sumOut` keeps its previous value.
- R5: While `rstN` is low, `outValid` and `sumOut` are zero.
- R6: The width W is a parameter. The function holds at W = 3 and at W = 5.
- R7: When opA + opB equals 2^W − 1 exactly (complementary operands), the result is zero. In the same way, when the raw sum exceeds 2^W − 1, the carry out is added back at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands are present this cycle |
| opA | input | W | First residue |
| opB | input | W | Second residue |
| outValid | output | 1 | `sumOut` holds a new result |
| sumOut | output | W | Registered modular sum |

## Verification
The assertions assume that `opA` and `opB` are settled, with no X bits, whenever `inValid` is high at an edge. They also assume that `rstN` stays low for at least one edge before operation. They put no range limit on the operands, because an all-ones operand is a legal alias of zero. The stimulus walks every operand pair at W = 3 and at W = 5, including the all-ones operands, and changes inputs only on falling edges. It drops `inValid` for short gaps between groups of operands, so that the hold behaviour is exercised while the expected results are still queued.

// File: rtl/eac_adder_pkg.sv
package eac_adder_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;   // capture a new sum this edge
  } eacStrobes_t;

  // Number of Sklansky levels for a given width
  function automatic int prefixLevels(input int width);
    return (width > 1) ? $clog2(width) : 1;
  endfunction

endpackage

// File: rtl/eac_prefix_tree.sv
// Sklansky prefix tree: grpG[i]/grpP[i] are group terms over bits i..0
module eac_prefix_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] genIn,
  input  logic [W-1:0] propIn,
  output logic [W-1:0] grpG,
  output logic [W-1:0] grpP
);
  localparam int LV = eac_adder_pkg::prefixLevels(W);

  logic [W-1:0] gLvl [LV+1];
  logic [W-1:0] pLvl [LV+1];

  always_comb begin
    gLvl[0] = genIn;
    pLvl[0] = propIn;
    for (int lv = 0; lv < LV; lv++) begin
      for (int i = 0; i < W; i++) begin
        if (((i >> lv) & 1) == 1) begin
          // combine with the last bit of the lower block at this level
          int j;
          j = ((i >> lv) << lv) - 1;
          gLvl[lv+1][i] = gLvl[lv][i] | (pLvl[lv][i] & gLvl[lv][j]);
          pLvl[lv+1][i] = pLvl[lv][i] & pLvl[lv][j];
        end else begin
          gLvl[lv+1][i] = gLvl[lv][i];
          pLvl[lv+1][i] = pLvl[lv][i];
        end
      end
    end
  end

  assign grpG = gLvl[LV];
  assign grpP = pLvl[LV];
endmodule

// File: rtl/eac_ctrl.sv
// Control: turns the input valid into a load strobe and the output flag
module eac_ctrl (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output eac_adder_pkg::eacStrobes_t strobes,
  output logic                       outValid
);
  always_comb begin
    strobes.load = inValid & rstN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/eac_datapath.sv
// Datapath: generate/propagate, prefix carries, end-around carry, zero fold
module eac_datapath #(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  eac_adder_pkg::eacStrobes_t strobes,
  input  logic [W-1:0]               opA,
  input  logic [W-1:0]               opB,
  output logic [W-1:0]               sumOut
);
  logic [W-1:0] genBits, propBits;
  logic [W-1:0] grpG, grpP;
  logic [W-1:0] carryIn;
  logic [W-1:0] rawSum, foldSum;
  logic         endCarry;

  assign genBits  = opA & opB;
  assign propBits = opA ^ opB;

  eac_prefix_tree #(.W(W)) tree (
    .genIn (genBits),
    .propIn(propBits),
    .grpG  (grpG),
    .grpP  (grpP)
  );

  // carry out of the whole word is returned to bit 0
  assign endCarry = grpG[W-1];

  always_comb begin
    carryIn[0] = endCarry;
    for (int i = 1; i < W; i++) begin
      carryIn[i] = grpG[i-1] | (grpP[i-1] & endCarry);
    end
  end

  assign rawSum  = propBits ^ carryIn;
  assign foldSum = (&rawSum) ? '0 : rawSum;

  always_ff @(posedge clk) begin
    if (!rstN)             sumOut <= '0;
    else if (strobes.load) sumOut <= foldSum;
  end
endmodule

// File: rtl/residue_eac_adder.sv
// Thin top: control plus datapath
module residue_eac_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         outValid,
  output logic [W-1:0] sumOut
);
  eac_adder_pkg::eacStrobes_t strobes;

  eac_ctrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  eac_datapath #(.W(W)) datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .sumOut (sumOut)
  );
endmodule

// File: rtl/eac_adder_checker.sv
module eac_adder_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         outValid,
  input logic [W-1:0] sumOut
);
  localparam int MOD = (1 << W) - 1;
  localparam logic [W-1:0] ALL1 = '1;

  int   refSum;
  logic wasReset;

  // reference built from plain "+" and "%"
  always_comb refSum = (int'(opA) + int'(opB)) % MOD;

  always_ff @(posedge clk) wasReset <= !rstN;

  // R5: values left by a reset edge are zero
  always @(posedge clk) begin
    if (wasReset) begin
      assert_reset_R5: assert (outValid == 1'b0 && sumOut == '0)
        else $error("reset state wrong");
    end
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(sumOut)));

  assert_no_allones_R2: assert property (@(posedge clk) disable iff (!rstN)
    sumOut != ALL1);

  assert_sum_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (int'(sumOut) == $past(refSum)));
endmodule

bind residue_eac_adder eac_adder_checker #(.W(W)) chk (.*);

// File: tb/tb_residue_eac_adder.sv
module tb_residue_eac_adder;
  localparam int PERIOD = 10;

  typedef struct {
    int a;
    int b;
    int exp;
  } item_t;

  logic clk = 0;
  logic rstN = 0;

  logic       inValid5 = 0, inValid3 = 0;
  logic [4:0] opA5 = '0, opB5 = '0;
  logic [2:0] opA3 = '0, opB3 = '0;
  logic       outValid5, outValid3;
  logic [4:0] sumOut5;
  logic [2:0] sumOut3;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  item_t q5[$];
  item_t q3[$];
  int last5 = 0, last3 = 0;

  always #(PERIOD/2) clk = ~clk;

  residue_eac_adder #(.W(5)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid5), .opA(opA5), .opB(opB5),
    .outValid(outValid5), .sumOut(sumOut5));

  residue_eac_adder #(.W(3)) dut3 (
    .clk(clk), .rstN(rstN), .inValid(inValid3), .opA(opA3), .opB(opB3),
    .outValid(outValid3), .sumOut(sumOut3));

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor for one width: compare against the queue, check hold and all-ones
  task automatic monitorStep(input int w, input logic v, input int s,
                             ref item_t q[$], ref int last);
    int all1 = (1 << w) - 1;
    if (v) begin
      if (q.size() == 0) begin
        check("R3 unexpected outValid", 1, 0);
      end else begin
        item_t it = q.pop_front();
        if (it.a + it.b == all1) check("R7 complement gives zero", s, it.exp);
        else if (it.a + it.b > all1) check("R7 end-around carry", s, it.exp);
        else check(w == 3 ? "R1 R6 sum w3" : "R1 R6 sum w5", s, it.exp);
        check("R2 no all-ones output", int'(s == all1), 0);
        last = s;
      end
    end else begin
      check("R4 hold while idle", s, last);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      monitorStep(5, outValid5, int'(sumOut5), q5, last5);
      monitorStep(3, outValid3, int'(sumOut3), q3, last3);
    end
  end

  task automatic drive5(input int a, input int b);
    item_t it;
    @(negedge clk);
    inValid5 = 1;
    opA5 = a[4:0];
    opB5 = b[4:0];
    it.a = a; it.b = b; it.exp = (a + b) % 31;
    q5.push_back(it);
  endtask

  task automatic drive3(input int a, input int b);
    item_t it;
    @(negedge clk);
    inValid3 = 1;
    opA3 = a[2:0];
    opB3 = b[2:0];
    it.a = a; it.b = b; it.exp = (a + b) % 7;
    q3.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid5 = 0;
      inValid3 = 0;
      opA5 = 5'h15; opB5 = 5'h0a;   // junk while idle must not matter (R4)
      opA3 = 3'h5;  opB3 = 3'h3;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    failCount++;
    testCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 reset outValid w5", int'(outValid5), 0);
    check("R5 reset sumOut w5", int'(sumOut5), 0);
    check("R5 reset outValid w3", int'(outValid3), 0);
    check("R5 reset sumOut w3", int'(sumOut3), 0);
    rstN = 1;
    idle(2);

    // exhaustive W=5 with gaps
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        drive5(a, b);
        if ((b % 11) == 10) idle(2);
      end
    end
    idle(3);

    // exhaustive W=3 with gaps
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        drive3(a, b);
        if ((b % 5) == 4) idle(1);
      end
    end
    idle(4);

    check("R3 all W5 results seen", q5.size(), 0);
    check("R3 all W3 results seen", q3.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule